// File: doc/BRIEF.md
# Four-Way Cache Tag Directory

This block keeps the tag and line state for a four-way set-associative data cache of 512 sets. Each line holds a 21-bit tag, a valid flag and a modified flag, and covers four 32-bit words of data held elsewhere. A lookup presents a set index and a tag. In the same cycle the block reports hit or miss, the hitting way, the way chosen for a fill on a miss and, when that victim holds modified data, a write-back request with the victim's way and tag. The directory state changes at the next clock edge: a write hit marks the line modified, and a miss installs the new tag as valid and clean.

Reset does not touch line state, so after power-up the directory holds garbage. A clear-all command sweeps one set per cycle and must finish before the cache is used. A per-line push command names a set and a way. It reports a write-back for a modified line and always leaves the line invalid. Data storage, the bus side and the transfer of write-back data belong to neighbouring blocks.

Top module: `cache_tag_dir`

## Requirements
- R1: A one-cycle pulse on `clr_all` while `busy` is low raises `busy` for exactly SETS (512) cycles. Afterwards every line in every way is invalid and clean, and the round-robin pointer of every set points at way 0.
- R2: Reset drives `busy` low and `ready` high and leaves tags and valid and modified flags unchanged. A line filled before a reset still hits after it.
- R3: A lookup (`req_valid` and `ready`) hits in the same cycle only on a valid line whose stored tag equals `req_tag`. `hit_way` gives the way as a binary number 0 to 3.
- R4: On a miss, `fill_way` names the lowest-numbered invalid way of the set. At the next edge that way takes the tag with valid set and modified clear.
- R5: When all four ways of the set are valid, a miss picks the way held in that set's round-robin pointer and advances the pointer by one, modulo 4.
- R6: A miss whose chosen victim is valid and modified raises `wb_req` in the same cycle, with `wb_way` set to the victim way and `wb_tag` set to its tag. A clean victim gives no `wb_req`.
- R7: A lookup with `req_write` high that hits sets the modified flag of the hitting line.
- R8: A push (`push_valid` while `busy` is low) on a valid modified line raises `wb_req` with that way and tag in the same cycle. Any push leaves the line invalid after the edge. A push on a clean or invalid line gives no `wb_req`.
- R9: `ready` is low while `busy` or `push_valid` is high. A lookup that is not accepted gives no `hit` and no `wb_req` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state only |
| clr_all | input | 1 | Start the clear-all sweep |
| busy | output | 1 | Sweep in progress |
| ready | output | 1 | Lookup accepted this cycle |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Lookup is a store |
| req_set | input | 9 | Set index |
| req_tag | input | 21 | Address tag |
| hit | output | 1 | Lookup hit |
| hit_way | output | 2 | Hitting way |
| fill_way | output | 2 | Way filled on a miss |
| push_valid | input | 1 | Push-and-invalidate command |
| push_set | input | 9 | Set of the pushed line |
| push_way | input | 2 | Way of the pushed line |
| wb_req | output | 1 | Modified line must be written back |
| wb_way | output | 2 | Way of the line to write back |
| wb_tag | output | 21 | Tag of the line to write back |

## Verification
Lookups run against sets that are empty, partly filled and full. This separates the lowest-invalid-way choice from the round-robin choice and shows that the pointer advances. Read hits and write hits on the same lines, followed by evictions, show that only lines made dirty by a write produce write-back requests. Pushes on clean and on dirty lines, and a push issued together with a lookup, show the write-back report, the invalidation and the stall. A reset between fills and lookups shows that line state survives reset, and a second sweep shows that the clear-all command alone empties the directory.

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int SETS  = 512,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  output logic             busy,
  output logic             ready,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [$clog2(SETS)-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic [1:0]       hit_way,
  output logic [1:0]       fill_way,
  input  logic             push_valid,
  input  logic [$clog2(SETS)-1:0] push_set,
  input  logic [1:0]       push_way,
  output logic             wb_req,
  output logic [1:0]       wb_way,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int WAYS  = 4;
  localparam int SET_W = $clog2(SETS);

  logic [WAYS-1:0]  vld   [SETS];
  logic [WAYS-1:0]  dirty [SETS];
  logic [1:0]       rr    [SETS];
  logic [TAG_W-1:0] tags  [SETS][WAYS];

  logic [SET_W-1:0] sweep;
  logic [WAYS-1:0]  match;
  logic [1:0]       free_way;
  logic             full, look, miss, push_go;

  assign ready   = !busy && !push_valid;
  assign look    = req_valid && ready;
  assign push_go = push_valid && !busy;
  assign full    = &vld[req_set];

  always_comb begin
    free_way = 2'd0;
    hit_way  = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = vld[req_set][w] && (tags[req_set][w] == req_tag);
      if (!vld[req_set][w]) free_way = 2'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = 2'(w);
  end

  assign hit      = look && (match != '0);
  assign miss     = look && (match == '0);
  assign fill_way = full ? rr[req_set] : free_way;

  always_comb begin
    wb_req = 1'b0;
    wb_way = fill_way;
    wb_tag = tags[req_set][fill_way];
    if (push_go) begin
      wb_way = push_way;
      wb_tag = tags[push_set][push_way];
      wb_req = vld[push_set][push_way] && dirty[push_set][push_way];
    end else if (miss) begin
      wb_req = full && dirty[req_set][fill_way];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy  <= 1'b0;
      sweep <= '0;
    end else if (busy) begin
      sweep <= sweep + 1'b1;
      if (sweep == SET_W'(SETS - 1)) busy <= 1'b0;
    end else if (clr_all) begin
      busy  <= 1'b1;
      sweep <= '0;
    end

  always_ff @(posedge clk)
    if (busy) begin
      vld[sweep]   <= '0;
      dirty[sweep] <= '0;
      rr[sweep]    <= 2'd0;
    end else if (push_go) begin
      vld[push_set][push_way]   <= 1'b0;
      dirty[push_set][push_way] <= 1'b0;
    end else if (hit) begin
      if (req_write) dirty[req_set][hit_way] <= 1'b1;
    end else if (miss) begin
      vld[req_set][fill_way]   <= 1'b1;
      dirty[req_set][fill_way] <= 1'b0;
      tags[req_set][fill_way]  <= req_tag;
      if (full) rr[req_set] <= rr[req_set] + 2'd1;
    end

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || push_valid) |-> (!ready && !hit)); // R9
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (vld[$past(req_set)][$past(fill_way)] && !dirty[$past(req_set)][$past(fill_way)]
              && tags[$past(req_set)][$past(fill_way)] == $past(req_tag))); // R4
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_write) |=> dirty[$past(req_set)][$past(hit_way)]); // R7
  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> !vld[$past(push_set)][$past(push_way)]); // R8
  AST_HIT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !wb_req); // R6
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sweep) == SET_W'(SETS - 1)); // R1
endmodule

// File: tb/cache_tag_dir_test.sv
module cache_tag_dir_test;
  logic clk = 0, rst_n = 0, clr_all = 0;
  logic req_valid = 0, req_write = 0, push_valid = 0;
  logic [8:0] req_set = 0, push_set = 0;
  logic [20:0] req_tag = 0;
  logic [1:0] push_way = 0;
  logic busy, ready, hit, wb_req;
  logic [1:0] hit_way, fill_way, wb_way;
  logic [20:0] wb_tag;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  cache_tag_dir uut (.clk, .rst_n, .clr_all, .busy, .ready, .req_valid, .req_write,
    .req_set, .req_tag, .hit, .hit_way, .fill_way, .push_valid, .push_set,
    .push_way, .wb_req, .wb_way, .wb_tag);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one lookup; checks taken before the updating edge
  task automatic look(input [8:0] s, input [20:0] t, input logic wr, input logic exp_hit,
                      input [1:0] exp_way, input logic exp_wb, input [20:0] exp_wtag, string req);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_set = s; req_tag = t;
    #1;
    chk({req, " hit"}, hit, exp_hit);
    chk({req, " way"}, exp_hit ? hit_way : fill_way, exp_way);
    chk({req, " wb"}, wb_req, exp_wb);
    if (exp_wb) chk({req, " wb_way/tag"}, {wb_way, wb_tag}, {exp_way, exp_wtag});
    @(posedge clk); #1 req_valid = 0; req_write = 0;
  endtask

  task automatic push(input [8:0] s, input [1:0] w, input logic exp_wb, input [20:0] exp_wtag);
    @(negedge clk);
    push_valid = 1; push_set = s; push_way = w; req_valid = 1; req_set = s; req_tag = exp_wtag;
    #1;
    chk("R8 push wb", wb_req, exp_wb);
    if (exp_wb) chk("R8 push wb_way/tag", {wb_way, wb_tag}, {w, exp_wtag});
    chk("R9 ready low during push", ready, 0);
    chk("R9 no hit during push", hit, 0);
    @(posedge clk); #1 push_valid = 0; req_valid = 0;
  endtask

  task automatic sweep_all();
    int n = 0;
    @(negedge clk); clr_all = 1;
    @(negedge clk); clr_all = 0; req_valid = 1; req_set = 7; req_tag = 21'h5;
    #1;
    chk("R9 ready low while busy", ready, 0);
    chk("R9 no hit while busy", hit, 0);
    while (busy && n < 2000) begin n++; @(negedge clk); #1; end
    req_valid = 0;
    chk("R1 sweep length", n, 512);
  endtask

  initial begin
    #20000000;
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R2 busy low in reset", busy, 0);
    chk("R2 ready high in reset", ready, 1);
    #20 rst_n = 1;
    sweep_all();
    look(0, 21'hA, 0, 0, 0, 0, 0, "R1 empty after sweep");
    look(511, 21'hB, 0, 0, 0, 0, 0, "R1 last set empty");
    look(0, 21'hA, 0, 1, 0, 0, 0, "R3 hit after fill");
    for (int w = 0; w < 4; w++)
      look(7, 21'h100 + 21'(w), 0, 0, 2'(w), 0, 0, "R4 lowest free way");
    look(7, 21'h102, 0, 1, 2, 0, 0, "R3 hit way2");
    look(7, 21'h101, 1, 1, 1, 0, 0, "R7 write hit");
    look(7, 21'h200, 0, 0, 0, 0, 0, "R5 victim way0 clean R6");
    look(7, 21'h201, 0, 0, 1, 1, 21'h101, "R6 dirty victim way1");
    look(7, 21'h202, 0, 0, 2, 0, 0, "R5 victim advances");
    look(7, 21'h101, 0, 0, 3, 0, 0, "R3 evicted tag misses");
    look(7, 21'h200, 0, 1, 0, 0, 0, "R4 refilled clean hits");
    push(0, 0, 0, 21'hA);
    look(0, 21'hA, 0, 0, 0, 0, 0, "R8 clean push invalidated");
    look(9, 21'h33, 1, 0, 0, 0, 0, "R4 fill set9");
    look(9, 21'h33, 1, 1, 0, 0, 0, "R7 write hit set9");
    push(9, 0, 1, 21'h33);
    look(9, 21'h33, 0, 0, 0, 0, 0, "R8 dirty push invalidated");
    @(negedge clk); rst_n = 0; #1;
    chk("R2 busy low in reset", busy, 0);
    @(negedge clk); rst_n = 1;
    look(7, 21'h202, 0, 1, 2, 0, 0, "R2 state kept over reset");
    sweep_all();
    look(7, 21'h202, 0, 0, 0, 0, 0, "R1 second sweep clears");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule